// File: doc/BRIEF.md
# CPU Interrupt and Reset Entry Sequencer

This block carries out the bus-level entry work of a 16-bit processor core that also has an 8-bit-compatible emulation mode. After power-up, after a soft reset, and when a non-maskable (NMI) or maskable (IRQ) interrupt is pending at an instruction boundary, it runs a fixed series of single-byte bus cycles. For interrupts it makes a dummy read, spends one internal cycle, saves the return state on the stack, fetches a vector and hands the updated registers back. For reset it fetches the reset vector and then holds off the first instruction fetch for a fixed number of clocks.

The core's current register values come in on `cur_*` inputs and are sampled when a sequence starts. The results leave on `new_*` outputs and are valid while `done` is high. `done` is high for one clock. On that clock `done_rst` tells the core whether to load every `new_*` field (reset) or only PC, program bank, status, emulation flag and stack pointer (interrupt). On a reset commit the core also zeroes its direct-page and data-bank registers, clears its data latch and leaves any wait state. The pending flags are levels owned by the core. The block only pulses `clr_nmi` or `clr_irq` for the request it served. A request that arrives while a sequence runs therefore stays pending and is taken at a later boundary.

Top module: `cpu_entry_seq`

## Requirements
- R1: When `rst_n` is released, the block reads 0x00FFFC and then 0x00FFFD. It then leaves WAKE_CLKS (default 186) clocks with no bus request and no `done`, and then pulses `done` with `done_rst`=1, new_pc={byte@FFFD,byte@FFFC}, new_pbr=0x00, new_p=0x34, new_e=1, new_s=0x01FF and new_a=new_x=new_y=0. While `rst_n` is low, `bus_req` and `done` are 0.
- R2: A one-clock `rst_req` aborts any sequence in progress and runs the same bus sequence as R1. It commits new_s={0x01,cur_s[7:0]}, new_a=cur_a, new_x={0x00,cur_x[7:0]} and new_y={0x00,cur_y[7:0]}.
- R3: An interrupt is accepted only while the block is idle and `insn_bound` is 1 with `nmi_pend` or `irq_pend` at 1. Otherwise the block issues no bus request, and it issues none on the clock after `done`.
- R4: When both requests are pending, the NMI is served first. With `done`, only the matching clear (`clr_nmi` or `clr_irq`) pulses, and neither pulses on a reset commit.
- R5: Vector addresses are 0xFFEA (NMI) and 0xFFEE (IRQ) when cur_e=0, and 0xFFFA (NMI) and 0xFFFE (IRQ) when cur_e=1. They are read in bank 0x00, the low byte first and then the high byte at vector+1.
- R6: Interrupt bus order is: read at {cur_pbr,cur_pc}, then one clock with no request, then the pushes, then the two vector reads, then `done` on the clock after the last acknowledge.
- R7: Pushes are writes in bank 0x00 at S, and S is decremented after each one. With cur_e=1 the address high byte is forced to 0x01 and only the low byte wraps. The order is program bank (only when cur_e=0), PC[15:8], PC[7:0], status. new_s is the final S.
- R8: With cur_e=1 the pushed status byte has bit 4 cleared. With cur_e=0 it is cur_p unchanged.
- R9: An interrupt commit gives new_pc={vector high,vector low}, new_pbr=0x00, new_p=cur_p with bit 2 set and bit 3 cleared, new_e=cur_e, and new_a/new_x/new_y equal to cur_a/cur_x/cur_y.
- R10: `bus_req` stays high with stable `bus_addr`, `bus_we` and `bus_wdata` until `bus_ack`, with one transaction at a time. Each step advances only on the acknowledge, for any acknowledge latency.
- R11: `done` lasts exactly one clock. A request raised while a sequence runs is served at the next boundary after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; its release starts the power-up sequence |
| rst_req | input | 1 | One-clock soft reset request |
| nmi_pend | input | 1 | NMI pending level |
| irq_pend | input | 1 | IRQ pending level |
| insn_bound | input | 1 | Instruction-boundary strobe |
| cur_e | input | 1 | Current emulation flag |
| cur_p | input | 8 | Current status register |
| cur_pbr | input | 8 | Current program bank |
| cur_pc | input | 16 | Current program counter |
| cur_s | input | 16 | Current stack pointer |
| cur_a | input | 16 | Current accumulator |
| cur_x | input | 16 | Current X index |
| cur_y | input | 16 | Current Y index |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 24 | Bus byte address {bank,offset} |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transaction acknowledge |
| done | output | 1 | One-clock completion pulse; `new_*` valid |
| done_rst | output | 1 | Completion belongs to a reset sequence |
| clr_nmi | output | 1 | Clear NMI pending (with `done`) |
| clr_irq | output | 1 | Clear IRQ pending (with `done`) |
| new_pc | output | 16 | Program counter to load |
| new_pbr | output | 8 | Program bank to load |
| new_p | output | 8 | Status register to load |
| new_e | output | 1 | Emulation flag to load |
| new_s | output | 16 | Stack pointer to load |
| new_a | output | 16 | Accumulator to load (reset commit) |
| new_x | output | 16 | X index to load (reset commit) |
| new_y | output | 16 | Y index to load (reset commit) |

## Verification
The hardest case to reach from the ports is a soft reset that lands in the middle of an interrupt entry, with a bus request held open by a slow acknowledge. The bench starts an IRQ entry with a long acknowledge latency, waits until a push is outstanding, and then pulses `rst_req`. Its reference model throws away the expected remainder of the interrupt and checks that the reset vector read follows at once. A second hard case is the emulation-mode stack wrap, which the bench reaches by starting with the stack pointer at 0x0101 so that the third push crosses from 0x0100 to 0x01FF.

// File: rtl/cpu_entry_pkg.sv
// Shared types and constants for the CPU entry sequencer.
// Assumes 24-bit byte addresses built as {bank, 16-bit offset}.
package cpu_entry_pkg;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_IDLE,
        ST_DUMMY,
        ST_INTERNAL,
        ST_PUSH_PB,
        ST_PUSH_PCH,
        ST_PUSH_PCL,
        ST_PUSH_P,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_RST_LO,
        ST_RST_HI,
        ST_WAKE,
        ST_FIN
    } seq_st_e;

    localparam logic [15:0] VEC_RESET   = 16'hFFFC;
    localparam logic [15:0] VEC_NMI_NAT = 16'hFFEA;
    localparam logic [15:0] VEC_IRQ_NAT = 16'hFFEE;
    localparam logic [15:0] VEC_NMI_EMU = 16'hFFFA;
    localparam logic [15:0] VEC_IRQ_EMU = 16'hFFFE;

    localparam logic [7:0]  P_AFTER_RESET = 8'h34;
    localparam int          P_BIT_IMASK   = 2;
    localparam int          P_BIT_DEC     = 3;
    localparam int          P_BIT_BRK     = 4;

    localparam logic [7:0]  ZERO_BANK     = 8'h00;
    localparam logic [7:0]  EMU_STACK_HI  = 8'h01;

endpackage

// File: rtl/ces_vec_pick.sv
// Interrupt arbitration and vector choice.
// Assumes: nmi_pend and irq_pend are levels; NMI outranks IRQ.
module ces_vec_pick
    import cpu_entry_pkg::*;
(
    input  logic        nmi_pend,
    input  logic        emu,
    output logic        take_nmi,
    output logic [15:0] vec
);

    // Pick the winning request and its vector for the current mode.
    always_comb begin
        take_nmi = nmi_pend;
        if (emu) vec = take_nmi ? VEC_NMI_EMU : VEC_IRQ_EMU;
        else     vec = take_nmi ? VEC_NMI_NAT : VEC_IRQ_NAT;
    end

endmodule

// File: rtl/ces_stack_step.sv
// Push address and post-decrement stack pointer.
// Assumes: pushes go to bank zero; in emulation mode the page is pinned to one.
module ces_stack_step
    import cpu_entry_pkg::*;
(
    input  logic [15:0] sp,
    input  logic        emu,
    output logic [23:0] push_addr,
    output logic [15:0] sp_next
);

    // Form the write address and the decremented pointer.
    always_comb begin
        if (emu) begin
            push_addr = {ZERO_BANK, EMU_STACK_HI, sp[7:0]};
            sp_next   = {EMU_STACK_HI, sp[7:0] - 8'd1};
        end else begin
            push_addr = {ZERO_BANK, sp};
            sp_next   = sp - 16'd1;
        end
    end

endmodule

// File: rtl/ces_wake_timer.sv
// Down-counter that measures the hold-off after the reset vector fetch.
// Assumes CLKS >= 1; load makes 'zero' go low for CLKS-1 further clocks.
module ces_wake_timer #(
    parameter int CLKS = 186
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic zero
);

    localparam int CW = (CLKS > 1) ? $clog2(CLKS) : 1;

    logic [CW-1:0] cnt;

    // Reload on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= CW'(CLKS - 1);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/cpu_entry_seq.sv
// CPU interrupt and reset entry sequencer (top).
// Runs the power-up/soft-reset vector fetch with a fixed hold-off, and the
// interrupt entry: dummy read, idle clock, stack pushes, vector fetch.
// Assumes: one bus transaction at a time, each step completes on bus_ack;
// cur_* are stable from sequence start until done.
module cpu_entry_seq
    import cpu_entry_pkg::*;
#(
    parameter int WAKE_CLKS = 186
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rst_req,
    input  logic        nmi_pend,
    input  logic        irq_pend,
    input  logic        insn_bound,
    input  logic        cur_e,
    input  logic [7:0]  cur_p,
    input  logic [7:0]  cur_pbr,
    input  logic [15:0] cur_pc,
    input  logic [15:0] cur_s,
    input  logic [15:0] cur_a,
    input  logic [15:0] cur_x,
    input  logic [15:0] cur_y,
    output logic        bus_req,
    output logic        bus_we,
    output logic [23:0] bus_addr,
    output logic [7:0]  bus_wdata,
    input  logic [7:0]  bus_rdata,
    input  logic        bus_ack,
    output logic        done,
    output logic        done_rst,
    output logic        clr_nmi,
    output logic        clr_irq,
    output logic [15:0] new_pc,
    output logic [7:0]  new_pbr,
    output logic [7:0]  new_p,
    output logic        new_e,
    output logic [15:0] new_s,
    output logic [15:0] new_a,
    output logic [15:0] new_x,
    output logic [15:0] new_y
);

    seq_st_e     st;
    logic [15:0] w_pc, w_s, w_vec;
    logic [7:0]  w_pbr, w_p, w_lo, w_hi;
    logic        w_e, w_nmi, w_rst, w_pwr;

    logic        take_nmi;
    logic [15:0] pick_vec;
    logic [23:0] push_addr;
    logic [15:0] sp_next;
    logic        tmr_load, tmr_zero;
    logic        is_push;
    logic        accept;

    ces_vec_pick u_pick (
        .nmi_pend (nmi_pend),
        .emu      (cur_e),
        .take_nmi (take_nmi),
        .vec      (pick_vec)
    );

    ces_stack_step u_stack (
        .sp        (w_s),
        .emu       (w_e),
        .push_addr (push_addr),
        .sp_next   (sp_next)
    );

    ces_wake_timer #(.CLKS(WAKE_CLKS)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .zero  (tmr_zero)
    );

    assign accept   = insn_bound && (nmi_pend || irq_pend);
    assign tmr_load = (st == ST_RST_HI) && bus_ack;
    assign is_push  = (st == ST_PUSH_PB) || (st == ST_PUSH_PCH) ||
                      (st == ST_PUSH_PCL) || (st == ST_PUSH_P);

    // Sequence state and working copies of the registers being saved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_BOOT;
            w_pc  <= '0;
            w_s   <= '0;
            w_vec <= '0;
            w_pbr <= '0;
            w_p   <= '0;
            w_lo  <= '0;
            w_hi  <= '0;
            w_e   <= 1'b1;
            w_nmi <= 1'b0;
            w_rst <= 1'b1;
            w_pwr <= 1'b1;
        end else if (rst_req) begin
            st    <= ST_RST_LO;
            w_rst <= 1'b1;
            w_pwr <= 1'b0;
        end else begin
            case (st)
                ST_BOOT:     st <= ST_RST_LO;
                ST_IDLE: if (accept) begin
                    w_pc  <= cur_pc;
                    w_pbr <= cur_pbr;
                    w_p   <= cur_p;
                    w_e   <= cur_e;
                    w_s   <= cur_s;
                    w_vec <= pick_vec;
                    w_nmi <= take_nmi;
                    w_rst <= 1'b0;
                    st    <= ST_DUMMY;
                end
                ST_DUMMY:    if (bus_ack) st <= ST_INTERNAL;
                ST_INTERNAL: st <= w_e ? ST_PUSH_PCH : ST_PUSH_PB;
                ST_PUSH_PB:  if (bus_ack) begin w_s <= sp_next; st <= ST_PUSH_PCH; end
                ST_PUSH_PCH: if (bus_ack) begin w_s <= sp_next; st <= ST_PUSH_PCL; end
                ST_PUSH_PCL: if (bus_ack) begin w_s <= sp_next; st <= ST_PUSH_P;   end
                ST_PUSH_P:   if (bus_ack) begin w_s <= sp_next; st <= ST_VEC_LO;   end
                ST_VEC_LO:   if (bus_ack) begin w_lo <= bus_rdata; st <= ST_VEC_HI; end
                ST_VEC_HI:   if (bus_ack) begin w_hi <= bus_rdata; st <= ST_FIN;    end
                ST_RST_LO:   if (bus_ack) begin w_lo <= bus_rdata; st <= ST_RST_HI; end
                ST_RST_HI:   if (bus_ack) begin w_hi <= bus_rdata; st <= ST_WAKE;   end
                ST_WAKE:     if (tmr_zero) st <= ST_FIN;
                ST_FIN: begin
                    st    <= ST_IDLE;
                    w_pwr <= 1'b0;
                end
                default:     st <= ST_IDLE;
            endcase
        end
    end

    // Bus request, direction, address and write data per step.
    always_comb begin
        bus_req   = is_push || (st == ST_DUMMY) || (st == ST_VEC_LO) ||
                    (st == ST_VEC_HI) || (st == ST_RST_LO) || (st == ST_RST_HI);
        bus_we    = is_push;
        bus_wdata = 8'h00;
        bus_addr  = push_addr;
        case (st)
            ST_DUMMY:    bus_addr = {w_pbr, w_pc};
            ST_VEC_LO:   bus_addr = {ZERO_BANK, w_vec};
            ST_VEC_HI:   bus_addr = {ZERO_BANK, w_vec + 16'd1};
            ST_RST_LO:   bus_addr = {ZERO_BANK, VEC_RESET};
            ST_RST_HI:   bus_addr = {ZERO_BANK, VEC_RESET + 16'd1};
            default:     bus_addr = push_addr;
        endcase
        case (st)
            ST_PUSH_PB:  bus_wdata = w_pbr;
            ST_PUSH_PCH: bus_wdata = w_pc[15:8];
            ST_PUSH_PCL: bus_wdata = w_pc[7:0];
            ST_PUSH_P: begin
                bus_wdata = w_p;
                if (w_e) bus_wdata[P_BIT_BRK] = 1'b0;
            end
            default:     bus_wdata = 8'h00;
        endcase
    end

    // Completion strobes and the register values handed back to the core.
    always_comb begin
        done     = (st == ST_FIN);
        done_rst = done && w_rst;
        clr_nmi  = done && !w_rst && w_nmi;
        clr_irq  = done && !w_rst && !w_nmi;
        new_pc   = {w_hi, w_lo};
        new_pbr  = ZERO_BANK;
        if (w_rst) begin
            new_p = P_AFTER_RESET;
            new_e = 1'b1;
            new_s = w_pwr ? {EMU_STACK_HI, 8'hFF} : {EMU_STACK_HI, cur_s[7:0]};
            new_a = w_pwr ? 16'h0000 : cur_a;
            new_x = w_pwr ? 16'h0000 : {8'h00, cur_x[7:0]};
            new_y = w_pwr ? 16'h0000 : {8'h00, cur_y[7:0]};
        end else begin
            new_p = w_p;
            new_p[P_BIT_IMASK] = 1'b1;
            new_p[P_BIT_DEC]   = 1'b0;
            new_e = w_e;
            new_s = w_s;
            new_a = cur_a;
            new_x = cur_x;
            new_y = cur_y;
        end
    end

endmodule

// File: rtl/ces_checker.sv
// Property checker for cpu_entry_seq, attached by bind below.
// Assumes it sees the top's ports only.
module ces_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rst_req,
    input logic        bus_req,
    input logic        bus_we,
    input logic [23:0] bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_ack,
    input logic        done,
    input logic        done_rst,
    input logic        clr_nmi,
    input logic        clr_irq,
    input logic [7:0]  new_p,
    input logic [7:0]  new_pbr
);

    // R10: an open request holds address, direction and data until acknowledged.
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !rst_req) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R11: completion is a single-clock pulse.
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: no bus activity on the clock after completion.
    assert_quiet_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rst_req) |=> !bus_req);

    // R4: at most one clear, only with an interrupt completion.
    assert_one_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_nmi || clr_irq) |-> (done && !done_rst && !(clr_nmi && clr_irq)));

    // R7: every push lands in bank zero.
    assert_push_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (bus_addr[23:16] == 8'h00));

    // R9: interrupt completion masks IRQ, clears decimal, zeroes the bank.
    assert_irq_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_rst) |-> (new_p[2] && !new_p[3] && new_pbr == 8'h00));

    // R1: reset completion hands back the fixed status value.
    assert_reset_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_rst |-> (new_p == 8'h34));

endmodule

bind cpu_entry_seq ces_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_req   (rst_req),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .done      (done),
    .done_rst  (done_rst),
    .clr_nmi   (clr_nmi),
    .clr_irq   (clr_irq),
    .new_p     (new_p),
    .new_pbr   (new_pbr)
);

// File: tb/cpu_entry_seq_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model kept as a queue of expected per-clock
// events, compared against the design on every falling edge.
module cpu_entry_seq_tb;

    localparam int WAKE = 186;
    localparam int K_BUS = 0, K_GAP = 1, K_DONE = 2;

    typedef struct {
        int          kind;
        int          tag;
        logic [23:0] addr;
        logic        we;
        logic [7:0]  data;
        int          cnt;
        logic [15:0] pc;
        logic [7:0]  p;
        logic        e;
        logic [15:0] s, a, x, y;
        logic        rst, cn, ci;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_req = 1'b0, nmi_r = 1'b0, irq_r = 1'b0, insn_bound = 1'b0;
    logic        cur_e = 1'b1;
    logic [7:0]  cur_p = 8'h00, cur_pbr = 8'h00;
    logic [15:0] cur_pc = 16'h0, cur_s = 16'h0, cur_a = 16'h0, cur_x = 16'h0, cur_y = 16'h0;
    logic        bus_req, bus_we, bus_ack = 1'b0;
    logic [23:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        done, done_rst, clr_nmi, clr_irq, new_e;
    logic [15:0] new_pc, new_s, new_a, new_x, new_y;
    logic [7:0]  new_pbr, new_p;

    exp_t q[$];
    int   nchk = 0, nfail = 0, lat = 0, wait_n = 0, cyc = 0;

    always #2 clk = ~clk;

    cpu_entry_seq #(.WAKE_CLKS(WAKE)) u_dut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req),
        .nmi_pend(nmi_r), .irq_pend(irq_r), .insn_bound(insn_bound),
        .cur_e(cur_e), .cur_p(cur_p), .cur_pbr(cur_pbr), .cur_pc(cur_pc),
        .cur_s(cur_s), .cur_a(cur_a), .cur_x(cur_x), .cur_y(cur_y),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .done(done), .done_rst(done_rst), .clr_nmi(clr_nmi), .clr_irq(clr_irq),
        .new_pc(new_pc), .new_pbr(new_pbr), .new_p(new_p), .new_e(new_e),
        .new_s(new_s), .new_a(new_a), .new_x(new_x), .new_y(new_y)
    );

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return (a[7:0] ^ 8'hA5) + a[15:8] + a[23:16];
    endfunction

    always_comb bus_rdata = mem_byte(bus_addr);

    function automatic exp_t mk(input int kind, input int tag);
        exp_t r;
        r = '{default: 0};
        r.kind = kind;
        r.tag  = tag;
        return r;
    endfunction

    task automatic add_bus(input int tag, input logic [23:0] a, input logic we, input logic [7:0] d);
        exp_t r;
        r = mk(K_BUS, tag);
        r.addr = a; r.we = we; r.data = d;
        q.push_back(r);
    endtask

    task automatic add_gap(input int tag, input int n);
        exp_t r;
        r = mk(K_GAP, tag);
        r.cnt = n;
        q.push_back(r);
    endtask

    // Reset model (R1 power-up, R2 soft reset).
    task automatic exp_reset(input bit pwr);
        exp_t r;
        add_bus(pwr ? 1 : 2, 24'h00FFFC, 1'b0, 8'h00);
        add_bus(pwr ? 1 : 2, 24'h00FFFD, 1'b0, 8'h00);
        add_gap(pwr ? 1 : 2, WAKE);
        r = mk(K_DONE, pwr ? 1 : 2);
        r.pc  = {mem_byte(24'h00FFFD), mem_byte(24'h00FFFC)};
        r.p   = 8'h34;
        r.e   = 1'b1;
        r.s   = pwr ? 16'h01FF : {8'h01, cur_s[7:0]};
        r.a   = pwr ? 16'h0 : cur_a;
        r.x   = pwr ? 16'h0 : {8'h00, cur_x[7:0]};
        r.y   = pwr ? 16'h0 : {8'h00, cur_y[7:0]};
        r.rst = 1'b1;
        q.push_back(r);
    endtask

    task automatic add_push(input int tag, input logic [7:0] d, inout logic [15:0] s);
        if (cur_e) begin
            add_bus(tag, {8'h00, 8'h01, s[7:0]}, 1'b1, d);
            s = {8'h01, s[7:0] - 8'd1};
        end else begin
            add_bus(tag, {8'h00, s}, 1'b1, d);
            s = s - 16'd1;
        end
    endtask

    // Interrupt model (R4 priority, R5 vectors, R6 order, R7 stack, R8 status, R9 commit).
    task automatic exp_irq();
        exp_t r;
        logic [15:0] v, s;
        logic nsel;
        nsel = nmi_r;
        v = cur_e ? (nsel ? 16'hFFFA : 16'hFFFE) : (nsel ? 16'hFFEA : 16'hFFEE);
        s = cur_s;
        add_bus(6, {cur_pbr, cur_pc}, 1'b0, 8'h00);
        add_gap(6, 1);
        if (!cur_e) add_push(7, cur_pbr, s);
        add_push(7, cur_pc[15:8], s);
        add_push(7, cur_pc[7:0], s);
        add_push(8, cur_e ? (cur_p & 8'hEF) : cur_p, s);
        add_bus(5, {8'h00, v}, 1'b0, 8'h00);
        add_bus(5, {8'h00, v + 16'd1}, 1'b0, 8'h00);
        r = mk(K_DONE, 9);
        r.pc = {mem_byte({8'h00, v + 16'd1}), mem_byte({8'h00, v})};
        r.p  = (cur_p | 8'h04) & 8'hF7;
        r.e  = cur_e;
        r.s  = s;
        r.a  = cur_a; r.x = cur_x; r.y = cur_y;
        r.rst = 1'b0; r.cn = nsel; r.ci = !nsel;
        q.push_back(r);
    endtask

    // One falling edge: compare outputs with the model, drive the acknowledge.
    task automatic tick();
        exp_t e;
        @(negedge clk);
        bus_ack = 1'b0;
        nchk++;
        if (q.size() == 0) begin
            if (bus_req || done) begin
                nfail++;
                $display("FAIL R3 cyc %0d: idle expected, got req=%b done=%b (expected 0 0)", cyc, bus_req, done);
            end
        end else begin
            e = q[0];
            if (e.kind == K_BUS) begin
                if (!bus_req || bus_addr != e.addr || bus_we != e.we || (e.we && bus_wdata != e.data)) begin
                    nfail++;
                    $display("FAIL R%0d cyc %0d: got req=%b addr=%h we=%b wd=%h, expected req=1 addr=%h we=%b wd=%h",
                             e.tag, cyc, bus_req, bus_addr, bus_we, bus_wdata, e.addr, e.we, e.data);
                end
                if (bus_req) begin
                    if (wait_n >= lat) begin
                        bus_ack = 1'b1;
                        wait_n = 0;
                        void'(q.pop_front());
                    end else begin
                        wait_n++;
                    end
                end
            end else if (e.kind == K_GAP) begin
                if (bus_req || done) begin
                    nfail++;
                    $display("FAIL R%0d cyc %0d: quiet clock expected, got req=%b done=%b (expected 0 0)",
                             e.tag, cyc, bus_req, done);
                end
                q[0].cnt = q[0].cnt - 1;
                if (q[0].cnt <= 0) void'(q.pop_front());
            end else begin
                if (!done || done_rst != e.rst || clr_nmi != e.cn || clr_irq != e.ci ||
                    new_pc != e.pc || new_pbr != 8'h00 || new_p != e.p || new_e != e.e ||
                    new_s != e.s || new_a != e.a || new_x != e.x || new_y != e.y) begin
                    nfail++;
                    $display("FAIL R%0d cyc %0d: got done=%b rst=%b cn=%b ci=%b pc=%h pbr=%h p=%h e=%b s=%h a=%h x=%h y=%h, expected done=1 rst=%b cn=%b ci=%b pc=%h pbr=00 p=%h e=%b s=%h a=%h x=%h y=%h",
                             e.tag, cyc, done, done_rst, clr_nmi, clr_irq, new_pc, new_pbr, new_p, new_e,
                             new_s, new_a, new_x, new_y, e.rst, e.cn, e.ci, e.pc, e.p, e.e, e.s, e.a, e.x, e.y);
                end
                void'(q.pop_front());
                cur_pc = e.pc; cur_pbr = 8'h00; cur_p = e.p; cur_e = e.e; cur_s = e.s;
                cur_a = e.a; cur_x = e.x; cur_y = e.y;
                if (e.cn) nmi_r = 1'b0;
                if (e.ci) irq_r = 1'b0;
            end
        end
    endtask

    task automatic run_idle();
        while (q.size() != 0) tick();
        tick();
    endtask

    // Instruction boundary pulse; the model accepts only with a request pending (R3).
    task automatic boundary();
        insn_bound = 1'b1;
        if (nmi_r || irq_r) exp_irq();
        tick();
        insn_bound = 1'b0;
    endtask

    task automatic soft_reset();
        rst_req = 1'b1;
        q.delete();
        wait_n = 0;
        exp_reset(1'b0);
        tick();
        rst_req = 1'b0;
    endtask

    // Watchdog: a hung run counts as a miscompare and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nfail++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        cur_a = 16'h1234; cur_x = 16'hBEEF; cur_y = 16'hCAFE; cur_s = 16'h0777;
        // R1: reset state, then power-up sequence
        repeat (3) tick();
        rst_n = 1'b1;
        exp_reset(1'b1);
        run_idle();

        // R2: soft reset from idle keeps A and the low bytes
        cur_a = 16'h5A5A; cur_x = 16'hABCD; cur_y = 16'h9876; cur_s = 16'h1F37;
        lat = 2;
        soft_reset();
        run_idle();

        // R3: pending IRQ without a boundary, then a boundary without a request
        irq_r = 1'b1;
        repeat (10) tick();
        irq_r = 1'b0;
        repeat (3) boundary();
        repeat (2) tick();

        // R6 R7 R9: native IRQ entry
        cur_e = 1'b0; cur_pbr = 8'h7E; cur_pc = 16'h8123; cur_p = 8'h1B; cur_s = 16'h1FF0;
        lat = 1;
        irq_r = 1'b1;
        boundary();
        run_idle();

        // R4: both pending, NMI first, then IRQ at the next boundary
        lat = 0;
        cur_pc = 16'h4455; cur_pbr = 8'h03; cur_p = 8'hC8;
        nmi_r = 1'b1; irq_r = 1'b1;
        boundary();
        run_idle();
        boundary();
        run_idle();

        // R11: NMI raised while an IRQ entry runs is taken afterwards
        lat = 1;
        irq_r = 1'b1;
        boundary();
        repeat (4) tick();
        nmi_r = 1'b1;
        run_idle();
        boundary();
        run_idle();

        // R5 R7 R8: emulation IRQ, break bit set, stack low byte wraps
        cur_e = 1'b1; cur_s = 16'h0101; cur_p = 8'h3B; cur_pc = 16'hC00D; cur_pbr = 8'h00;
        lat = 0;
        irq_r = 1'b1;
        boundary();
        run_idle();

        // R5 R10: emulation NMI with slow acknowledge
        cur_s = 16'h01F0; cur_p = 8'h10;
        lat = 3;
        nmi_r = 1'b1;
        boundary();
        run_idle();

        // R2 R10: soft reset aborts an entry with a push outstanding
        cur_e = 1'b0; cur_s = 16'h0420;
        lat = 5;
        irq_r = 1'b1;
        boundary();
        repeat (12) tick();
        soft_reset();
        run_idle();
        irq_r = 1'b0;
        repeat (3) tick();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule